// File: doc/BRIEF.md
# Encoder Index Conditioner and Flag Selector

This block takes the once-per-revolution index pulse of an incremental encoder, brings it into the clock domain, corrects its polarity and steers it to exactly one counter control action. On the load side the index either reloads the position counter from its preset or captures the counter into the read-out latch. On the reset side it either clears the counter or gates A/B counting by its level. Load, capture and clear are single-cycle strobes, one per active edge of the index. The gate is a level.

The same block picks which counter events drive two flag lines. These flags feed interrupt logic and the cascade input of a neighbouring counter. The counter and the interrupt logic sit outside. Every input here is a plain control or status pin, and no data path crosses the block, so it has no valid/ready handshake.

Top module: `idx_router`

## Requirements
- R1: While reset is asserted, all three strobes, the gate output and both flag outputs are 0.
- R2: With `idx_en_i` = 0, the index pin has no effect: no strobe is issued, `ab_gate_o` is 1, and the index flag source reads 0.
- R3: `idx_pol_i` = 1 makes a rising pin edge (high level) active. `idx_pol_i` = 0 makes a falling edge (low level) active. An edge of the other direction produces no strobe.
- R4: With `idx_route_i` = 0 and `ld_fn_i` = 0, each active edge gives exactly one `load_cnt_o` pulse, one cycle long. The pulse is high in the cycle after the third rising clock edge that follows the pin change (two synchroniser stages plus one output register).
- R5: With `idx_route_i` = 0 and `ld_fn_i` = 1, each active edge gives exactly one `latch_cnt_o` pulse and no load pulse.
- R6: With `idx_route_i` = 1 and `rs_fn_i` = 0, each active edge gives exactly one `clear_cnt_o` pulse. The load-side strobes stay 0.
- R7: With `idx_en_i` = 1, `idx_route_i` = 1 and `rs_fn_i` = 1, `ab_gate_o` follows the active level of the index with the same latency as the strobes, and no strobe is issued. In every other configuration `ab_gate_o` is 1.
- R8: `flag_sel_i` = 00: flag A carries `ev_carry_i` and flag B carries `ev_borrow_i`. Both flags are registered, so each is one cycle behind its source.
- R9: `flag_sel_i` = 01: flag A carries `ev_cmp_i` and flag B carries `ev_borrow_i`.
- R10: `flag_sel_i` = 10: flag A carries carry OR borrow and flag B carries `ev_up_i` (1 = up).
- R11: `flag_sel_i` = 11: flag A carries the enabled, polarity-corrected index level, with the strobe latency. Flag B carries `ev_err_i`.
- R12: Changing `idx_pol_i` while the pin is steady produces no strobe.
- R13: A pin that is already at its active level when reset is released produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_pin_i | input | 1 | Raw index input, asynchronous |
| idx_en_i | input | 1 | Index enable |
| idx_pol_i | input | 1 | Index polarity, 1 = active high |
| idx_route_i | input | 1 | 0 = load side, 1 = reset side |
| ld_fn_i | input | 1 | Load side: 0 = load from preset, 1 = capture into latch |
| rs_fn_i | input | 1 | Reset side: 0 = clear counter, 1 = A/B gate |
| flag_sel_i | input | 2 | Flag output source select |
| ev_carry_i | input | 1 | Counter carry event |
| ev_borrow_i | input | 1 | Counter borrow event |
| ev_cmp_i | input | 1 | Counter compare match |
| ev_up_i | input | 1 | Count direction, 1 = up |
| ev_err_i | input | 1 | Counter error status |
| load_cnt_o | output | 1 | Strobe: load counter from preset |
| latch_cnt_o | output | 1 | Strobe: capture counter into latch |
| clear_cnt_o | output | 1 | Strobe: clear counter |
| ab_gate_o | output | 1 | A/B counting allowed |
| flag_a_o | output | 1 | Flag output A |
| flag_b_o | output | 1 | Flag output B |

## Verification
The hardest cases to reach from the ports involve an index that is already active with no fresh edge. One is a pin held active straight through reset release. The other is a polarity flip on a steady pin, which turns an inactive level into an active one without any pin transition. The stimulus creates both directly and counts strobes over a window afterwards. Edge direction is separated from level in the same way: a window opens after each pin transition, so a strobe is credited to the rising or the falling transition alone. Latency is pinned down by sampling the strobe on the clock edges just before and just after the expected one.

// File: rtl/idx_router_pkg.sv
package idx_router_pkg;

  typedef enum logic [1:0] {
    FLG_CY_BW   = 2'b00,
    FLG_CMP_BW  = 2'b01,
    FLG_ANY_DIR = 2'b10,
    FLG_IDX_ERR = 2'b11
  } flag_sel_e;

  typedef struct packed {
    logic load_cnt;
    logic latch_cnt;
    logic clear_cnt;
  } idx_stb_t;

endpackage

// File: rtl/idx_sync_edge.sv
module idx_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic lvl_o,
  output logic edge_o
);
  localparam int WARM_MAX = SYNC_STAGES + 1;
  localparam int WARM_W   = $clog2(WARM_MAX + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [WARM_W-1:0]      warm_q;
  logic                   last_s;
  logic                   cur_act;
  logic                   prev_act;

  // Synchroniser chain; the stage count is a parameter.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= pin_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign last_s = sync_q[SYNC_STAGES-1];

  // The raw synchronised value is kept, not the polarity-corrected one,
  // so a polarity change on a steady pin cannot look like an edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= last_s;
  end

  // Warm-up count: outputs are qualified until the chain holds real samples.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              warm_q <= '0;
    else if (warm_q != WARM_W'(WARM_MAX))     warm_q <= warm_q + 1'b1;
  end

  assign cur_act  = pol_i ? last_s : ~last_s;
  assign prev_act = pol_i ? prev_q : ~prev_q;
  assign lvl_o    = cur_act & (warm_q >= WARM_W'(SYNC_STAGES));
  assign edge_o   = cur_act & ~prev_act & (warm_q == WARM_W'(WARM_MAX));

endmodule

// File: rtl/idx_steer.sv
module idx_steer
  import idx_router_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     route_i,
  input  logic     ld_fn_i,
  input  logic     rs_fn_i,
  input  logic     act_edge_i,
  input  logic     act_lvl_i,
  output idx_stb_t stb_o,
  output logic     gate_o
);
  idx_stb_t stb_d, stb_q;
  logic     gate_mode;
  logic     gate_q;

  assign gate_mode = en_i & route_i & rs_fn_i;

  always_comb begin
    stb_d           = '0;
    stb_d.load_cnt  = en_i & act_edge_i & ~route_i & ~ld_fn_i;
    stb_d.latch_cnt = en_i & act_edge_i & ~route_i &  ld_fn_i;
    stb_d.clear_cnt = en_i & act_edge_i &  route_i & ~rs_fn_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      stb_q  <= stb_d;
      gate_q <= ~gate_mode | act_lvl_i;
    end
  end

  assign stb_o  = stb_q;
  assign gate_o = gate_q;

endmodule

// File: rtl/idx_flag_mux.sv
module idx_flag_mux
  import idx_router_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       carry_i,
  input  logic       borrow_i,
  input  logic       cmp_i,
  input  logic       up_i,
  input  logic       err_i,
  input  logic       idx_i,
  output logic       flag_a_o,
  output logic       flag_b_o
);
  logic a_d, b_d;
  logic a_q, b_q;

  always_comb begin
    unique case (flag_sel_e'(sel_i))
      FLG_CY_BW:   begin a_d = carry_i;            b_d = borrow_i; end
      FLG_CMP_BW:  begin a_d = cmp_i;              b_d = borrow_i; end
      FLG_ANY_DIR: begin a_d = carry_i | borrow_i; b_d = up_i;     end
      default:     begin a_d = idx_i;              b_d = err_i;    end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign flag_a_o = a_q;
  assign flag_b_o = b_q;

endmodule

// File: rtl/idx_router.sv
module idx_router
  import idx_router_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_pin_i,
  input  logic       idx_en_i,
  input  logic       idx_pol_i,
  input  logic       idx_route_i,
  input  logic       ld_fn_i,
  input  logic       rs_fn_i,
  input  logic [1:0] flag_sel_i,
  input  logic       ev_carry_i,
  input  logic       ev_borrow_i,
  input  logic       ev_cmp_i,
  input  logic       ev_up_i,
  input  logic       ev_err_i,
  output logic       load_cnt_o,
  output logic       latch_cnt_o,
  output logic       clear_cnt_o,
  output logic       ab_gate_o,
  output logic       flag_a_o,
  output logic       flag_b_o
);
  logic     act_lvl;
  logic     act_edge;
  idx_stb_t stb;

  idx_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (idx_pin_i),
    .pol_i  (idx_pol_i),
    .lvl_o  (act_lvl),
    .edge_o (act_edge)
  );

  idx_steer u_steer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (idx_en_i),
    .route_i    (idx_route_i),
    .ld_fn_i    (ld_fn_i),
    .rs_fn_i    (rs_fn_i),
    .act_edge_i (act_edge),
    .act_lvl_i  (act_lvl),
    .stb_o      (stb),
    .gate_o     (ab_gate_o)
  );

  idx_flag_mux u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (flag_sel_i),
    .carry_i  (ev_carry_i),
    .borrow_i (ev_borrow_i),
    .cmp_i    (ev_cmp_i),
    .up_i     (ev_up_i),
    .err_i    (ev_err_i),
    .idx_i    (idx_en_i & act_lvl),
    .flag_a_o (flag_a_o),
    .flag_b_o (flag_b_o)
  );

  assign load_cnt_o  = stb.load_cnt;
  assign latch_cnt_o = stb.latch_cnt;
  assign clear_cnt_o = stb.clear_cnt;

endmodule

// File: rtl/idx_router_chk.sv
module idx_router_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       idx_en_i,
  input logic       idx_route_i,
  input logic       ld_fn_i,
  input logic       rs_fn_i,
  input logic [1:0] flag_sel_i,
  input logic       ev_carry_i,
  input logic       ev_borrow_i,
  input logic       load_cnt_o,
  input logic       latch_cnt_o,
  input logic       clear_cnt_o,
  input logic       ab_gate_o,
  input logic       flag_a_o,
  input logic       flag_b_o
);
  AST_STB_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_cnt_o, latch_cnt_o, clear_cnt_o}));                          // R4

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_cnt_o |=> !load_cnt_o);                                                 // R4

  AST_LATCH_NEEDS_FN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_cnt_o |-> $past(ld_fn_i) && !$past(idx_route_i));                     // R5

  AST_CLEAR_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_cnt_o |-> $past(idx_route_i) && !$past(rs_fn_i));                     // R6

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_en_i |=> !(load_cnt_o || latch_cnt_o || clear_cnt_o));                  // R2

  AST_GATE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(idx_en_i && idx_route_i && rs_fn_i) |=> ab_gate_o);                        // R7

  AST_FLAG_CY_BW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_sel_i == 2'b00) |=> (flag_a_o == $past(ev_carry_i)) &&
                              (flag_b_o == $past(ev_borrow_i)));                 // R8

  AST_FLAG_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_sel_i == 2'b10) |=> (flag_a_o == ($past(ev_carry_i) || $past(ev_borrow_i)))); // R10

  AST_IDX_FLAG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_en_i && flag_sel_i == 2'b11) |=> !flag_a_o);                           // R11
endmodule

bind idx_router idx_router_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .idx_en_i    (idx_en_i),
  .idx_route_i (idx_route_i),
  .ld_fn_i     (ld_fn_i),
  .rs_fn_i     (rs_fn_i),
  .flag_sel_i  (flag_sel_i),
  .ev_carry_i  (ev_carry_i),
  .ev_borrow_i (ev_borrow_i),
  .load_cnt_o  (load_cnt_o),
  .latch_cnt_o (latch_cnt_o),
  .clear_cnt_o (clear_cnt_o),
  .ab_gate_o   (ab_gate_o),
  .flag_a_o    (flag_a_o),
  .flag_b_o    (flag_b_o)
);

// File: tb/idx_router_bench.sv
module idx_router_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, en = 1'b0, pol = 1'b1, route = 1'b0, ldf = 1'b0, rsf = 1'b0;
  logic [1:0] fsel = 2'b00;
  logic cy = 1'b0, bw = 1'b0, cmp = 1'b0, up = 1'b0, err = 1'b0;
  logic load, latch, clr, gate, fa, fb;

  int n_chk = 0, n_bad = 0;
  int c_ld = 0, c_lt = 0, c_cl = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  idx_router u_idx_router (
    .clk_i(clk), .rst_ni(rst_n), .idx_pin_i(pin), .idx_en_i(en), .idx_pol_i(pol),
    .idx_route_i(route), .ld_fn_i(ldf), .rs_fn_i(rsf), .flag_sel_i(fsel),
    .ev_carry_i(cy), .ev_borrow_i(bw), .ev_cmp_i(cmp), .ev_up_i(up), .ev_err_i(err),
    .load_cnt_o(load), .latch_cnt_o(latch), .clear_cnt_o(clr), .ab_gate_o(gate),
    .flag_a_o(fa), .flag_b_o(fb)
  );

  // {sel[1:0], carry, borrow, cmp, up, err, expA, expB}
  localparam logic [8:0] FLAG_VEC [9] = '{
    9'b00_10000_10, 9'b00_01111_01, 9'b01_10100_10, 9'b01_01000_01,
    9'b10_10000_10, 9'b10_01010_11, 9'b10_00010_01, 9'b11_10001_01,
    9'b11_11110_00
  };

  task automatic check(input int got, input int exp, input string req);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1ns;
    if (load)  c_ld++;
    if (latch) c_lt++;
    if (clr)   c_cl++;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clr_cnt();
    c_ld = 0; c_lt = 0; c_cl = 0;
  endtask

  // Drive the pin at a falling clock edge, then count strobes over n cycles.
  task automatic window(input logic v, input int n);
    @(negedge clk); pin = v; clr_cnt(); ticks(n);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      finish_run();
    end
  end

  initial begin
    // R1 / R13: pin active high through reset
    en = 1'b1; pol = 1'b1; pin = 1'b1;
    ticks(3);
    check(int'({load, latch, clr, gate, fa, fb}), 0, "R1");
    @(negedge clk); rst_n = 1'b1; clr_cnt();
    ticks(10);
    check(c_ld, 0, "R13");

    // Flag table walk (R8..R11), index disabled
    en = 1'b0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      {fsel, cy, bw, cmp, up, err} = FLAG_VEC[i][8:2];
      tick();
      case (FLAG_VEC[i][8:7])
        2'b00:   begin check(fa, FLAG_VEC[i][1], "R8");  check(fb, FLAG_VEC[i][0], "R8");  end
        2'b01:   begin check(fa, FLAG_VEC[i][1], "R9");  check(fb, FLAG_VEC[i][0], "R9");  end
        2'b10:   begin check(fa, FLAG_VEC[i][1], "R10"); check(fb, FLAG_VEC[i][0], "R10"); end
        default: begin check(fa, FLAG_VEC[i][1], "R11"); check(fb, FLAG_VEC[i][0], "R11"); end
      endcase
    end

    // R2: disabled index, pulses ignored, gate open even in gate config
    route = 1'b1; rsf = 1'b1; fsel = 2'b11; err = 1'b0;
    window(1'b0, 6); window(1'b1, 6);
    check(c_ld + c_lt + c_cl, 0, "R2");
    check(gate, 1, "R2");
    check(fa, 0, "R2");
    route = 1'b0; rsf = 1'b0; ldf = 1'b0;
    window(1'b0, 6);
    check(c_ld + c_lt + c_cl, 0, "R2");

    // R4: exact latency, enabled, rising active
    en = 1'b1;
    ticks(4);
    @(negedge clk); pin = 1'b1;
    tick(); tick();
    check(load, 0, "R4");
    tick();
    check(load, 1, "R4");
    tick();
    check(load, 0, "R4");
    // R3 / R4: rising edge counts once, falling edge not at all
    window(1'b0, 6);
    check(c_ld, 0, "R3");
    window(1'b1, 6);
    check(c_ld, 1, "R4");
    check(c_lt + c_cl, 0, "R4");
    window(1'b0, 6);
    // R3: negative polarity, falling edge active
    pol = 1'b0;
    window(1'b1, 6);
    check(c_ld, 0, "R3");
    window(1'b0, 6);
    check(c_ld, 1, "R3");
    window(1'b1, 6);
    pol = 1'b1;

    // R12: polarity flips on a steady pin
    window(1'b1, 6);
    @(negedge clk); pol = 1'b0; clr_cnt(); ticks(5);
    @(negedge clk); pol = 1'b1; ticks(5);
    check(c_ld + c_lt + c_cl, 0, "R12");
    window(1'b0, 6);

    // R5: capture into latch
    ldf = 1'b1;
    window(1'b1, 6);
    check(c_lt, 1, "R5");
    check(c_ld + c_cl, 0, "R5");
    window(1'b0, 6);

    // R6: clear
    route = 1'b1; rsf = 1'b0;
    window(1'b1, 6);
    check(c_cl, 1, "R6");
    check(c_ld + c_lt, 0, "R6");
    window(1'b0, 6);

    // R7: gate follows level, no strobes
    rsf = 1'b1;
    ticks(2);
    check(gate, 0, "R7");
    @(negedge clk); pin = 1'b1; clr_cnt();
    tick(); tick();
    check(gate, 0, "R7");
    tick();
    check(gate, 1, "R7");
    ticks(4);
    check(c_ld + c_lt + c_cl, 0, "R7");
    // R11: index flag shows active level
    fsel = 2'b11; err = 1'b1;
    ticks(2);
    check(fa, 1, "R11");
    check(fb, 1, "R11");
    window(1'b0, 6);
    check(gate, 0, "R7");
    route = 1'b0;
    ticks(2);
    check(gate, 1, "R7");

    done = 1'b1;
    finish_run();
  end
endmodule